// File: doc/BRIEF.md
# Serial ADC Data Output Shifter

This block is the device side of a three-wire serial readout for an analog-to-digital converter. The host pulls the active-low select line low to open a frame; that edge also stands for the start of conversion. At that moment the block captures the parallel conversion result and turns on its data driver. It first sends four zero bits. It then sends the result with the most significant bit first, moving to the next bit on each falling edge of the host serial clock, so the host can sample on rising edges. After the last result bit, the block turns its driver off on the falling edge that closes the frame.

The result width is a parameter and may be 12, 10 or 8 bits. The frame length is always the result width plus four: 16, 14 or 12 clocks. Select and serial clock come from the host and are asynchronous to the block clock. Each one passes through a two-stage synchronizer, so the outputs react on the third rising `clk` edge after a host edge. The host serial clock phases must therefore each last at least three `clk` periods. The sample word must be held steady until that third edge after select falls. The pad buffer uses `sdata_oe_o` as its enable.

If select rises in mid-frame, the frame is abandoned and the driver turns off at once. If the host keeps clocking past the frame end, the extra edges see a released line until select goes high again.

Top module: `adc_sdata_shifter`

## Requirements
- R1: While `rst_n` is low, and after reset until the first select falling edge, `sdata_oe_o`, `busy_o` and `sdata_o` are all 0.
- R2: The third rising `clk` edge after `cs_n` falls opens a frame. `sdata_oe_o` and `busy_o` become 1, the sample is captured, and frame bit 0 is presented. Every new frame starts again at bit 0.
- R3: Frame bits 0 to 3 are 0. Frame bit k (k ≥ 1) is presented after the k-th falling edge of `sclk` within the frame.
- R4: Frame bits 4 to RES_W+3 carry the captured sample, bit RES_W-1 first and bit 0 last.
- R5: The (RES_W+4)-th falling `sclk` edge of a frame clears `sdata_oe_o`: at the 16th edge for RES_W=12, the 14th for 10 and the 12th for 8.
- R6: After the frame end, further `sclk` edges leave `sdata_oe_o` at 0 while `busy_o` stays 1. Both are 0 after `cs_n` returns high.
- R7: A rise of `cs_n` before the frame end clears `sdata_oe_o` and `busy_o` on the third `clk` edge after it. The next frame starts only on a new `cs_n` fall.
- R8: Changes to `sample_i` after capture do not alter the bits sent in the current frame.
- R9: `sdata_o` is 0 whenever `sdata_oe_o` is 0.
- R10: `sclk` edges while `cs_n` is high open no frame and leave all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it samples the host lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Host select, active low; its fall opens a frame |
| sclk | input | 1 | Host serial clock; bits advance on its falling edges |
| sample_i | input | RES_W | Conversion result, captured when a frame opens |
| sdata_o | output | 1 | Serial data bit toward the pad |
| sdata_oe_o | output | 1 | Pad driver enable; 0 means the line is released |
| busy_o | output | 1 | High from frame start until `cs_n` returns high |

## Verification
Three instances run side by side, one for each result width, all driven by the same select and clock. The same stimulus therefore gives exact frames for one width and overrun frames for the others, which separates the release edge count of each width. Fixed sample words of all ones, all zeros and alternating bits show the leading-zero span apart from the data. Random words catch bit order and off-by-one shifts. Random clock counts cover frames that are short (aborted), exact and overrunning. Random words written over the sample input in mid-frame show whether capture happens only at frame start. Clocking with select high shows that idle edges are ignored.

// File: rtl/adc_shift_pkg.sv
package adc_shift_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } frame_state_e;

  localparam int LEAD_ZEROS = 4;

  function automatic int frame_len(input int res_w);
    return res_w + LEAD_ZEROS;
  endfunction

  function automatic bit width_ok(input int res_w);
    return (res_w == 12) || (res_w == 10) || (res_w == 8);
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic cur_o,
  output logic prev_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign cur_o  = sync_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import adc_shift_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             oe_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

  frame_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cs_fall_i) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          load_o  = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cs_rise_i) begin
          state_d = ST_IDLE;
        end else if (sclk_fall_i) begin
          if (cnt_q == LAST_BIT) begin
            state_d = ST_HOLD;
          end else begin
            cnt_d   = cnt_q + 1'b1;
            cnt_en  = 1'b1;
            shift_o = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cs_rise_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign oe_o   = (state_q == ST_SHIFT);
  assign busy_o = (state_q != ST_IDLE);
  assign cnt_o  = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_BIT); // R5

  AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cs_fall_i) |=> (state_q == ST_SHIFT && cnt_q == '0)); // R2

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && cs_rise_i) |=> (state_q == ST_IDLE)); // R7

  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && !cs_rise_i && sclk_fall_i && cnt_q == LAST_BIT) |=> (state_q == ST_HOLD)); // R5

  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !cs_rise_i) |=> (state_q == ST_HOLD)); // R6

  AST_IDLE_IGNORES_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !cs_fall_i) |=> (state_q == ST_IDLE)); // R10

endmodule

// File: rtl/out_shifter.sv
module out_shifter #(
  parameter int RES_W     = 12,
  parameter int LEAD      = 4,
  parameter int FRAME_LEN = RES_W + LEAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             oe_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdata_o
);

  logic [FRAME_LEN-1:0] sreg_q, sreg_d;
  logic                 sreg_en;

  always_comb begin
    sreg_en = load_i | shift_i;
    if (load_i) sreg_d = {{LEAD{1'b0}}, sample_i};
    else        sreg_d = {sreg_q[FRAME_LEN-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else if (sreg_en) sreg_q <= sreg_d;
  end

  assign sdata_o = oe_i & sreg_q[FRAME_LEN-1];

  AST_LATCH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sreg_q[RES_W-1:0] == $past(sample_i))); // R8

  AST_LEAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sreg_q[FRAME_LEN-1 -: LEAD] == '0)); // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(sreg_q)); // R8

endmodule

// File: rtl/adc_sdata_shifter.sv
module adc_sdata_shifter
  import adc_shift_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic             busy_o
);

  localparam int FRAME_LEN = frame_len(RES_W);
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int N_LINES   = 2;
  localparam int IDX_SCLK  = 0;
  localparam int IDX_CS    = 1;

  generate
    if (!width_ok(RES_W)) begin : g_bad_width
      $error("adc_sdata_shifter: RES_W must be 12, 10 or 8");
    end
  endgenerate

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N_LINES-1:0] line_raw, line_cur, line_prev;
  assign line_raw = {cs_n, sclk};

  genvar gi;
  generate
    for (gi = 0; gi < N_LINES; gi++) begin : g_line_sync
      edge_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
      ) u_sync (
        .clk    (clk),
        .rst_n  (rst_sync_q),
        .d_i    (line_raw[gi]),
        .cur_o  (line_cur[gi]),
        .prev_o (line_prev[gi])
      );
    end
  endgenerate

  logic cs_fall, cs_rise, sclk_fall;
  assign cs_fall   =  line_prev[IDX_CS]   & ~line_cur[IDX_CS];
  assign cs_rise   = ~line_prev[IDX_CS]   &  line_cur[IDX_CS];
  assign sclk_fall =  line_prev[IDX_SCLK] & ~line_cur[IDX_SCLK];

  logic             load, shift, oe, busy;
  logic [CNT_W-1:0] bit_cnt;

  frame_ctrl #(
    .FRAME_LEN (FRAME_LEN),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .sclk_fall_i (sclk_fall),
    .load_o      (load),
    .shift_o     (shift),
    .oe_o        (oe),
    .busy_o      (busy),
    .cnt_o       (bit_cnt)
  );

  out_shifter #(
    .RES_W     (RES_W),
    .LEAD      (LEAD_ZEROS),
    .FRAME_LEN (FRAME_LEN)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load_i   (load),
    .shift_i  (shift),
    .oe_i     (oe),
    .sample_i (sample_i),
    .sdata_o  (sdata_o)
  );

  assign sdata_oe_o = oe;
  assign busy_o     = busy;

  AST_LEAD_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (oe && bit_cnt < CNT_W'(LEAD_ZEROS)) |-> !sdata_o); // R3

  AST_OE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    sdata_oe_o |-> busy_o); // R6

  AST_CS_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (line_cur[IDX_CS] && line_prev[IDX_CS]) |=> !sdata_oe_o); // R7

endmodule

// File: tb/adc_sdata_shifter_tb.sv
`timescale 1ns/1ps
module adc_sdata_shifter_tb;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sample = '0;

  logic [2:0] sd, oe, bz;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_sdata_shifter #(.RES_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_i(sample),
    .sdata_o(sd[0]), .sdata_oe_o(oe[0]), .busy_o(bz[0]));

  adc_sdata_shifter #(.RES_W(10)) u_dut10 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_i(sample[11:2]),
    .sdata_o(sd[1]), .sdata_oe_o(oe[1]), .busy_o(bz[1]));

  adc_sdata_shifter #(.RES_W(8)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_i(sample[11:4]),
    .sdata_o(sd[2]), .sdata_oe_o(oe[2]), .busy_o(bz[2]));

  function automatic int width_of(input int d);
    return (d == 0) ? 12 : (d == 1) ? 10 : 8;
  endfunction

  function automatic logic exp_bit(input int k, input logic [11:0] s, input int w);
    logic [11:0] v;
    v = s >> (12 - w);
    if (k < 4) return 1'b0;
    return v[w - 1 - (k - 4)];
  endfunction

  task automatic chk(input string req, input string what, input int d,
                     input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s width=%0d actual=%b expected=%b t=%0t",
               req, what, width_of(d), act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    for (int d = 0; d < 3; d++) begin
      chk(req, "oe", d, oe[d], 1'b0);
      chk(req, "busy", d, bz[d], 1'b0);
      chk("R9", "sdata", d, sd[d], 1'b0);
    end
  endtask

  task automatic check_edge(input int k, input logic [11:0] s, input bit scr);
    for (int d = 0; d < 3; d++) begin
      int n;
      n = width_of(d) + 4;
      if (k < n) begin
        chk(k == 0 ? "R2" : "R3", "oe", d, oe[d], 1'b1);
        chk("R2", "busy", d, bz[d], 1'b1);
        chk(k < 4 ? "R3" : (scr ? "R8" : "R4"), "sdata", d, sd[d], exp_bit(k, s, width_of(d)));
      end else begin
        chk(k == n ? "R5" : "R6", "oe", d, oe[d], 1'b0);
        chk("R6", "busy", d, bz[d], 1'b1);
        chk("R9", "sdata", d, sd[d], 1'b0);
      end
    end
  endtask

  task automatic run_frame(input logic [11:0] s, input int nclk, input bit scr);
    sample = s;
    cs_n = 1'b0;
    wait_n(H);
    if (scr) sample = 12'($urandom);
    check_edge(0, s, scr);
    for (int k = 1; k <= nclk; k++) begin
      sclk = 1'b0;
      wait_n(H);
      if (scr) sample = 12'($urandom);
      check_edge(k, s, scr);
      sclk = 1'b1;
      wait_n(H);
    end
    cs_n = 1'b1;
    wait_n(H);
    check_idle(nclk < 16 ? "R7" : "R6");
  endtask

  initial begin
    void'($urandom(32'h5EED_0A7C));
    wait_n(3);
    check_idle("R1");
    rst_n = 1'b1;
    wait_n(H);
    check_idle("R1");

    // R10: clocking with select high opens nothing
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b0; wait_n(H); check_idle("R10");
      sclk = 1'b1; wait_n(H); check_idle("R10");
    end

    run_frame(12'hFFF, 16, 1'b0);     // R5 exact for 12-bit, overrun for others
    run_frame(12'h000, 16, 1'b0);     // R4 all zeros
    run_frame(12'hA5A, 20, 1'b0);     // R6 overrun on every width
    run_frame(12'h5A5, 14, 1'b0);     // R5 exact for 10-bit
    run_frame(12'hC3C, 12, 1'b0);     // R5 exact for 8-bit
    run_frame(12'hFFF, 5, 1'b0);      // R7 abort inside data
    run_frame(12'h800, 2, 1'b0);      // R7 abort inside zeros
    run_frame(12'h9E1, 16, 1'b1);     // R8 sample scrambled mid-frame
    run_frame(12'h001, 0, 1'b0);      // R7 select pulse with no clocks

    for (int i = 0; i < 40; i++) begin
      run_frame(12'($urandom), int'($urandom_range(0, 20)), 1'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule